// File: doc/BRIEF.md
# Multi-Line Tagged Receive Queue

This block gathers characters from several serial line receivers into one shared first-in-first-out queue. Every stored entry carries the number of the line that produced it, the character (masked to the configured character size) and three error flags: overrun, framing and parity. Software drains the queue through a single read port. Each read presents the oldest entry with a valid bit and removes it. An empty queue reads as all zeros, so the host loops until the valid bit drops.

Each line has a parameter register, written through one shared write port. A write names the target line and carries the character size, stop-bit select, parity enable, odd-parity select, a baud code and a receive-enable bit. The framing fields and the baud code go out to the bit-level receivers, which sit outside this block. The block uses the size and the enable itself. No break flag exists: a break shows up as a zero character with the framing flag set. A receive interrupt is raised when the queue holds data and the interrupt enable is set.

Top module: `rx_line_queue`

## Requirements
- R1: A read word has this layout: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 line number, bits 7:0 character. Entries leave in arrival order. A pulse on `rbuf_pop` while data is present removes the oldest entry, and the next word is visible one cycle later.
- R2: While the queue is empty, `rbuf_word` is 0 and `rx_done` is 0. A pop on an empty queue has no effect.
- R3: A character that arrives on a line whose receive-enable bit is 0 is not stored and changes nothing.
- R4: Size code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. The stored character keeps only that many low bits, and the upper bits are zero.
- R5: The framing and parity flags of the receiver are stored unchanged with the character. A break is stored as character 0 with the framing flag set, and no other bit marks it.
- R6: Characters that arrive in the same cycle on several lines are queued in ascending line order.
- R7: `rx_irq` is 1 exactly when the queue is not empty and the interrupt enable (`ctl_rie`, latched by `ctl_wr`) is 1.
- R8: The queue holds DEPTH entries. A character that finds no free slot is dropped, and the next entry written after that has its overrun flag set. Later entries have it clear. Within one cycle, lower lines take the free slots first.
- R9: A parameter write uses these fields: bits 3:0 line, 5:4 size code, 6 stop, 7 parity enable, 8 odd parity, 12:9 baud code, 13 receive enable. Codes 0..14 select the rates 50, 75, 110, 134, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200 and 9600, in that order. Code 15 leaves the line's baud code unchanged, while the other fields still update. A write to a line number of NLINES or above changes nothing. `line_cfg` shows each line's settings in 7 bits: bit 0 stop, bit 1 parity enable, bit 2 odd, bits 6:3 baud code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | NLINES | One-cycle strobe per line: a character is ready |
| line_char | input | NLINES*8 | Received character per line (line i at bits 8i+7:8i) |
| line_perr | input | NLINES | Parity error with the character |
| line_ferr | input | NLINES | Framing error with the character |
| lp_wr | input | 1 | Line parameter write strobe |
| lp_data | input | 14 | Line parameter write data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rie | input | 1 | Receive interrupt enable value for a control write |
| rbuf_pop | input | 1 | Read side effect: remove the oldest entry |
| rbuf_word | output | 16 | Oldest entry with its valid bit, or 0 when empty |
| rx_done | output | 1 | Queue holds at least one entry |
| rx_irq | output | 1 | Receive interrupt |
| line_cfg | output | NLINES*7 | Per-line framing and baud settings for the receivers |

## Verification
Single characters on one line check the word layout. Back-to-back characters on different lines check ordering across cycles. Several lines strobing in the same cycle, in sparse and full patterns, show whether the ascending-line rule holds or whether slots collide. Characters of all ones under each size code show whether the mask truncates at the right width. A zero character with the framing flag checks the break encoding. The queue is also filled to the brim and then hit with extra characters, from one line and from two lines in the same cycle. This shows whether a drop is flagged on exactly the next written entry and whether the lower line wins the last slot.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
   localparam int CHAR_W  = 8;
   localparam int LINE_FW = 4;
   localparam int CFG_OUT_W = 7;

   typedef struct packed {
      logic              ovr;
      logic              ferr;
      logic              perr;
      logic [LINE_FW-1:0] line;
      logic [CHAR_W-1:0]  ch;
   } rlq_entry_t;

   localparam int WORD_W = $bits(rlq_entry_t) + 1;

   typedef struct packed {
      logic       en;
      logic [3:0] baud;
      logic       odd;
      logic       par;
      logic       stop;
      logic [1:0] size;
   } rlq_lcfg_t;

   localparam logic [3:0] BAUD_KEEP = 4'hF;

   function automatic logic [CHAR_W-1:0] size_mask(input logic [1:0] sz);
      return 8'hFF >> (2'd3 - sz);
   endfunction
endpackage

// File: rtl/rlq_capture.sv
module rlq_capture #(
   parameter int LINE_IDX = 0
) (
   input  logic                   in_valid,
   input  logic [7:0]             in_char,
   input  logic                   in_perr,
   input  logic                   in_ferr,
   input  logic                   rx_en,
   input  logic [1:0]             char_size,
   output logic                   req,
   output rlq_pkg::rlq_entry_t    ent
);
   assign req = in_valid & rx_en;

   always_comb begin
      ent      = '0;
      ent.ferr = in_ferr;
      ent.perr = in_perr;
      ent.line = rlq_pkg::LINE_FW'(LINE_IDX);
      ent.ch   = in_char & rlq_pkg::size_mask(char_size);
   end
endmodule

// File: rtl/rlq_slotter.sv
module rlq_slotter #(
   parameter int NLINES = 4,
   parameter int DEPTH  = 64,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(NLINES + 1)
) (
   input  logic [NLINES-1:0]    req,
   input  logic [CW-1:0]        fill,
   output logic [NLINES-1:0]    wr_en,
   output logic [NLINES*AW-1:0] slot,
   output logic [NW-1:0]        nwr,
   output logic                 drop
);
   localparam int SW = $clog2(DEPTH + NLINES + 1);

   always_comb begin
      logic [SW-1:0] acc;
      acc   = '0;
      wr_en = '0;
      slot  = '0;
      drop  = 1'b0;
      for (int i = 0; i < NLINES; i++) begin
         slot[i*AW +: AW] = acc[AW-1:0];
         if (req[i]) begin
            if (SW'(fill) + acc < SW'(DEPTH)) begin
               wr_en[i] = 1'b1;
               acc      = acc + SW'(1);
            end else begin
               drop = 1'b1;
            end
         end
      end
      nwr = NW'(acc);
   end
endmodule

// File: rtl/rlq_store.sv
module rlq_store #(
   parameter int NLINES = 4,
   parameter int DEPTH  = 64,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(NLINES + 1)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NLINES-1:0]                    wr_en,
   input  logic [NLINES*AW-1:0]                 slot,
   input  rlq_pkg::rlq_entry_t [NLINES-1:0]     ents,
   input  logic [NW-1:0]                        nwr,
   input  logic                                 pop,
   output logic [CW-1:0]                        fill,
   output rlq_pkg::rlq_entry_t                  head
);
   rlq_pkg::rlq_entry_t mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] fill_q;
   logic          pop_ok;

   assign pop_ok = pop && (fill_q != '0);

   always_ff @(posedge clk) begin
      for (int i = 0; i < NLINES; i++) begin
         if (wr_en[i]) mem[wp_q + slot[i*AW +: AW]] <= ents[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
      end else begin
         wp_q   <= wp_q + AW'(nwr);
         rp_q   <= rp_q + AW'(pop_ok);
         fill_q <= fill_q + CW'(nwr) - CW'(pop_ok);
      end
   end

   assign fill = fill_q;
   assign head = mem[rp_q];
endmodule

// File: rtl/rx_line_queue.sv
module rx_line_queue #(
   parameter int NLINES = 4,
   parameter int DEPTH  = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NLINES-1:0]     line_valid,
   input  logic [NLINES*8-1:0]   line_char,
   input  logic [NLINES-1:0]     line_perr,
   input  logic [NLINES-1:0]     line_ferr,
   input  logic                  lp_wr,
   input  logic [13:0]           lp_data,
   input  logic                  ctl_wr,
   input  logic                  ctl_rie,
   input  logic                  rbuf_pop,
   output logic [15:0]           rbuf_word,
   output logic                  rx_done,
   output logic                  rx_irq,
   output logic [NLINES*7-1:0]   line_cfg
);
   import rlq_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int NW = $clog2(NLINES + 1);

   if (NLINES < 2 || NLINES > 16) begin : g_bad_lines
      $error("rx_line_queue: NLINES must be 2..16");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < NLINES) begin : g_bad_depth
      $error("rx_line_queue: DEPTH must be a power of two and at least NLINES");
   end
   if (WORD_W != 16) begin : g_bad_word
      $error("rx_line_queue: entry layout must fill 16 bits");
   end

   // Line parameter register file
   rlq_lcfg_t         cfg_q [NLINES];
   logic [3:0]        lp_line;
   logic [3:0]        lp_baud;
   logic [NLINES-1:0] rx_en_vec;
   logic              rie_q;

   assign lp_line = lp_data[3:0];
   assign lp_baud = lp_data[12:9];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NLINES; i++) begin
         if (!rst_n) begin
            cfg_q[i] <= '0;
         end else if (lp_wr && lp_line == 4'(i)) begin
            cfg_q[i].size <= lp_data[5:4];
            cfg_q[i].stop <= lp_data[6];
            cfg_q[i].par  <= lp_data[7];
            cfg_q[i].odd  <= lp_data[8];
            cfg_q[i].en   <= lp_data[13];
            if (lp_baud != BAUD_KEEP) cfg_q[i].baud <= lp_baud;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rie_q <= 1'b0;
      else if (ctl_wr) rie_q <= ctl_rie;
   end

   // Per-line capture
   logic [NLINES-1:0]         cap_req;
   rlq_entry_t [NLINES-1:0]   cap_ent;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      rlq_capture #(.LINE_IDX(g)) u_cap (
         .in_valid  (line_valid[g]),
         .in_char   (line_char[g*8 +: 8]),
         .in_perr   (line_perr[g]),
         .in_ferr   (line_ferr[g]),
         .rx_en     (cfg_q[g].en),
         .char_size (cfg_q[g].size),
         .req       (cap_req[g]),
         .ent       (cap_ent[g])
      );
      assign rx_en_vec[g] = cfg_q[g].en;
      assign line_cfg[g*7 +: 7] = {cfg_q[g].baud, cfg_q[g].odd, cfg_q[g].par, cfg_q[g].stop};
   end

   // Slot assignment in ascending line order
   logic [NLINES-1:0]    wr_en;
   logic [NLINES*AW-1:0] slot;
   logic [NW-1:0]        nwr;
   logic                 drop;
   logic [CW-1:0]        fill_w;

   rlq_slotter #(.NLINES(NLINES), .DEPTH(DEPTH)) u_slot (
      .req   (cap_req),
      .fill  (fill_w),
      .wr_en (wr_en),
      .slot  (slot),
      .nwr   (nwr),
      .drop  (drop)
   );

   // Overrun carried to the next written entry
   logic ovr_q;
   rlq_entry_t [NLINES-1:0] ent_w;

   always_comb begin
      for (int i = 0; i < NLINES; i++) begin
         ent_w[i]     = cap_ent[i];
         ent_w[i].ovr = ovr_q && (slot[i*AW +: AW] == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          ovr_q <= 1'b0;
      else if (drop)       ovr_q <= 1'b1;
      else if (nwr != '0)  ovr_q <= 1'b0;
   end

   rlq_entry_t head;

   rlq_store #(.NLINES(NLINES), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .slot  (slot),
      .ents  (ent_w),
      .nwr   (nwr),
      .pop   (rbuf_pop),
      .fill  (fill_w),
      .head  (head)
   );

   assign rx_done   = (fill_w != '0);
   assign rbuf_word = rx_done ? {1'b1, head} : '0;
   assign rx_irq    = rx_done & rie_q;
endmodule

// File: rtl/rlq_checker.sv
module rlq_checker #(
   parameter int NLINES = 4,
   parameter int DEPTH  = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NLINES-1:0] line_valid,
   input logic [NLINES-1:0] rx_en,
   input logic [CW-1:0]     fill,
   input logic              ovr,
   input logic              rbuf_pop,
   input logic [15:0]       rbuf_word,
   input logic              rx_done,
   input logic              rx_irq,
   input logic              ctl_wr,
   input logic              ctl_rie
);
   AST_EMPTY_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> rbuf_word == 16'h0000); // R2
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_done && (line_valid & rx_en) == '0) |=> !rx_done); // R2
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_valid & rx_en) == '0 && !rbuf_pop) |=> $stable(fill)); // R3
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_rie) |=> !rx_irq); // R7
   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rbuf_word[15]); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH)); // R8
   AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CW'(DEPTH) && (line_valid & rx_en) != '0) |=> ovr); // R8
endmodule

bind rx_line_queue rlq_checker #(.NLINES(NLINES), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_valid (line_valid),
   .rx_en      (rx_en_vec),
   .fill       (fill_w),
   .ovr        (ovr_q),
   .rbuf_pop   (rbuf_pop),
   .rbuf_word  (rbuf_word),
   .rx_done    (rx_done),
   .rx_irq     (rx_irq),
   .ctl_wr     (ctl_wr),
   .ctl_rie    (ctl_rie)
);

// File: tb/rx_line_queue_tb.sv
`timescale 1ns/1ps
module rx_line_queue_tb;
   localparam int NL = 4;
   localparam int DP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] line_valid = '0;
   logic [NL*8-1:0] line_char = '0;
   logic [NL-1:0] line_perr = '0;
   logic [NL-1:0] line_ferr = '0;
   logic          lp_wr = 1'b0;
   logic [13:0]   lp_data = '0;
   logic          ctl_wr = 1'b0;
   logic          ctl_rie = 1'b0;
   logic          rbuf_pop = 1'b0;
   logic [15:0]   rbuf_word;
   logic          rx_done, rx_irq;
   logic [NL*7-1:0] line_cfg;

   int n_cmp = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   rx_line_queue #(.NLINES(NL), .DEPTH(DP)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_char(line_char),
      .line_perr(line_perr), .line_ferr(line_ferr), .lp_wr(lp_wr), .lp_data(lp_data),
      .ctl_wr(ctl_wr), .ctl_rie(ctl_rie), .rbuf_pop(rbuf_pop), .rbuf_word(rbuf_word),
      .rx_done(rx_done), .rx_irq(rx_irq), .line_cfg(line_cfg)
   );

   function automatic logic [15:0] w(input bit o, input bit f, input bit p,
                                     input int ln, input logic [7:0] c);
      return {1'b1, o, f, p, 4'(ln), c};
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cfg_line(input int ln, input int sz, input bit en, input int baud,
                           input bit stop, input bit par, input bit odd);
      lp_data = {en, 4'(baud), odd, par, stop, 2'(sz), 4'(ln)};
      lp_wr = 1'b1;
      @(negedge clk);
      lp_wr = 1'b0;
   endtask

   task automatic ctl(input bit rie);
      ctl_rie = rie; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic deliver(input logic [NL-1:0] m, input logic [NL*8-1:0] ch,
                          input logic [NL-1:0] pe, input logic [NL-1:0] fe);
      line_valid = m; line_char = ch; line_perr = pe; line_ferr = fe;
      @(negedge clk);
      line_valid = '0; line_perr = '0; line_ferr = '0;
   endtask

   task automatic one(input int ln, input logic [7:0] c);
      logic [NL*8-1:0] v;
      v = '0;
      v[ln*8 +: 8] = c;
      deliver(NL'(1) << ln, v, '0, '0);
   endtask

   task automatic pop_chk(input string rq, input logic [15:0] exp);
      chk(rq, rbuf_word, exp);
      rbuf_pop = 1'b1;
      @(negedge clk);
      rbuf_pop = 1'b0;
   endtask

   task automatic all_on();
      for (int i = 0; i < NL; i++) cfg_line(i, 3, 1'b1, 14, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      chk("R2 reset word", rbuf_word, 0);
      chk("R2 reset done", rx_done, 0);
      chk("R7 reset irq", rx_irq, 0);
      chk("R9 reset cfg", line_cfg, 0);
   endtask

   task automatic t_basic();
      all_on();
      one(2, 8'hA5);
      chk("R1 done after char", rx_done, 1);
      pop_chk("R1 single entry", w(0, 0, 0, 2, 8'hA5));
      chk("R2 empty after pop", rbuf_word, 0);
      one(1, 8'h11);
      one(3, 8'h22);
      pop_chk("R1 order first", w(0, 0, 0, 1, 8'h11));
      pop_chk("R1 order second", w(0, 0, 0, 3, 8'h22));
   endtask

   task automatic t_empty_pop();
      rbuf_pop = 1'b1; @(negedge clk); rbuf_pop = 1'b0;
      chk("R2 pop on empty", rx_done, 0);
      one(0, 8'h33);
      pop_chk("R2 no corruption after empty pop", w(0, 0, 0, 0, 8'h33));
   endtask

   task automatic t_disabled();
      cfg_line(1, 3, 1'b0, 14, 1'b0, 1'b0, 1'b0);
      one(1, 8'h44);
      chk("R3 disabled line stores nothing", rbuf_word, 0);
      deliver(4'b0011, {8'h0, 8'h0, 8'h45, 8'h46}, '0, '0);
      pop_chk("R3 only enabled line", w(0, 0, 0, 0, 8'h46));
      chk("R3 nothing else", rx_done, 0);
      cfg_line(1, 3, 1'b1, 14, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_size();
      cfg_line(0, 0, 1'b1, 14, 1'b0, 1'b0, 1'b0);
      one(0, 8'hFF);
      pop_chk("R4 size 5 bits", w(0, 0, 0, 0, 8'h1F));
      cfg_line(0, 1, 1'b1, 14, 1'b0, 1'b0, 1'b0);
      one(0, 8'hC3);
      pop_chk("R4 size 6 bits", w(0, 0, 0, 0, 8'h03));
      cfg_line(0, 2, 1'b1, 14, 1'b0, 1'b0, 1'b0);
      one(0, 8'hFF);
      pop_chk("R4 size 7 bits", w(0, 0, 0, 0, 8'h7F));
      cfg_line(0, 3, 1'b1, 14, 1'b0, 1'b0, 1'b0);
      one(0, 8'hFF);
      pop_chk("R4 size 8 bits", w(0, 0, 0, 0, 8'hFF));
   endtask

   task automatic t_errors();
      deliver(4'b1000, '0, '0, 4'b1000);
      pop_chk("R5 break as null with framing", w(0, 1, 0, 3, 8'h00));
      deliver(4'b0100, {8'h0, 8'h55, 16'h0}, 4'b0100, '0);
      pop_chk("R5 parity flag", w(0, 0, 1, 2, 8'h55));
   endtask

   task automatic t_order();
      deliver(4'b1101, {8'hA3, 8'hA2, 8'h00, 8'hA0}, '0, '0);
      pop_chk("R6 sparse first", w(0, 0, 0, 0, 8'hA0));
      pop_chk("R6 sparse second", w(0, 0, 0, 2, 8'hA2));
      pop_chk("R6 sparse third", w(0, 0, 0, 3, 8'hA3));
      deliver(4'b1111, {8'hB3, 8'hB2, 8'hB1, 8'hB0}, 4'b0010, 4'b1000);
      pop_chk("R6 full line0", w(0, 0, 0, 0, 8'hB0));
      pop_chk("R6 full line1", w(0, 0, 1, 1, 8'hB1));
      pop_chk("R6 full line2", w(0, 0, 0, 2, 8'hB2));
      pop_chk("R6 full line3", w(0, 1, 0, 3, 8'hB3));
   endtask

   task automatic t_irq();
      one(1, 8'h61);
      chk("R7 irq off when disabled", rx_irq, 0);
      ctl(1'b1);
      chk("R7 irq with data and enable", rx_irq, 1);
      pop_chk("R7 drain", w(0, 0, 0, 1, 8'h61));
      chk("R7 irq off when empty", rx_irq, 0);
      ctl(1'b0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < DP; i++) one(0, 8'(i));
      deliver(4'b0110, {8'h0, 8'hEE, 8'hEE, 8'h0}, '0, '0);
      for (int i = 0; i < DP; i++) pop_chk("R8 kept entries", w(0, 0, 0, 0, 8'(i)));
      chk("R8 drained", rx_done, 0);
      one(3, 8'h77);
      pop_chk("R8 overrun on next entry", w(1, 0, 0, 3, 8'h77));
      one(3, 8'h78);
      pop_chk("R8 overrun cleared", w(0, 0, 0, 3, 8'h78));
      for (int i = 0; i < DP - 1; i++) one(2, 8'(i));
      deliver(4'b0011, {16'h0, 8'hC1, 8'hC0}, '0, '0);
      for (int i = 0; i < DP - 1; i++) pop_chk("R8 fill entries", w(0, 0, 0, 2, 8'(i)));
      pop_chk("R8 lower line takes last slot", w(0, 0, 0, 0, 8'hC0));
      one(1, 8'h90);
      pop_chk("R8 overrun after same-cycle drop", w(1, 0, 0, 1, 8'h90));
   endtask

   task automatic t_params();
      cfg_line(1, 3, 1'b1, 5, 1'b1, 1'b1, 1'b0);
      chk("R9 cfg line1", line_cfg[7 +: 7], {4'd5, 1'b0, 1'b1, 1'b1});
      cfg_line(1, 3, 1'b1, 15, 1'b1, 1'b1, 1'b1);
      chk("R9 reserved baud keeps code", line_cfg[7 +: 7], {4'd5, 1'b1, 1'b1, 1'b1});
      cfg_line(5, 3, 1'b0, 2, 1'b0, 1'b0, 1'b0);
      chk("R9 out-of-range line ignored", line_cfg[7 +: 7], {4'd5, 1'b1, 1'b1, 1'b1});
      one(1, 8'h5A);
      pop_chk("R9 out-of-range write kept enable", w(0, 0, 0, 1, 8'h5A));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_err++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_empty_pop();
      t_disabled();
      t_size();
      t_errors();
      t_order();
      t_irq();
      t_overflow();
      t_params();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule